// File: doc/BRIEF.md
# Hidden Configuration Register Window

This block watches a byte-wide I/O port window that normally reaches the drive task file. While the window is locked, every host access passes straight through and is marked by a forwarding strobe. A specific access pattern unlocks it: two back-to-back 16-bit reads at offset 1, then a byte write of 3 to offset 2. Once unlocked, the same offsets reach internal configuration registers. These are the read-cycle and write-cycle timing registers, a control register, a miscellaneous register and a version register. A byte write of 0x83 to offset 2 locks the window again.

The timing registers exist once per bank, A and B, and the miscellaneous register chooses which bank host accesses reach. The control register decides which bank each of the two drives takes its timings from. The block drives the per-drive timing bytes and the decoded miscellaneous fields into a downstream timing generator.

Top module: `hcw_window`

## Requirements
- R1: After reset the window is locked, every timing, control and miscellaneous register holds 0, bank A is selected and access to bank B is disabled.
- R2: While locked, a 16-bit read at offset 1, then another 16-bit read at offset 1, then a byte write of 0x03 to offset 2 makes `cfg_unlocked` high from the cycle after that write.
- R3: While locked, any access that breaks that order resets the sequence detector. This includes a write between the reads, a byte-wide read at offset 1, a read at another offset, or a wrong key. A third or later consecutive wide read at offset 1 keeps the detector armed.
- R4: While locked, every valid access raises `taskfile_stb` in the same cycle and `acc_rdata` reads 0. No timing, control, miscellaneous or bank-select state changes while locked, except as stated in R10.
- R5: While unlocked, no access raises `taskfile_stb`. A byte write of 0x83 to offset 2 makes `cfg_unlocked` low from the next cycle. Any other write to offset 2 is ignored.
- R6: While unlocked, offset 0 reads and writes the read-cycle timing byte of the active bank, and offset 1 reads and writes the write-cycle timing byte of the active bank.
- R7: While unlocked, writing 0 or 1 to offset 6 selects bank A or bank B. Any other value is stored as the miscellaneous byte, and reading offset 6 returns that byte. From the stored byte, bit 6 drives `cfg_prefetch`, bits 5:4 drive `cfg_setup` and bits 2:1 drive `cfg_rdy_dly`.
- R8: While unlocked, offset 3 reads and writes the control byte. Drive 0 always uses bank A timings. Drive 1 uses bank B timings only while the control byte equals 0x85; otherwise it uses bank A.
- R9: While unlocked, offset 5 is a version register that reads 0. Offsets 2, 4 and 7 read 0, and writes to offsets 4, 5 and 7 change nothing.
- R10: A write of 0xC0 to offset 3 while locked enables bank-B access until reset. Until then, the active bank is A even when bank B is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | Host access present this cycle |
| acc_we | input | 1 | 1 = write, 0 = read |
| acc_wide | input | 1 | 1 = 16-bit access, 0 = byte access |
| acc_off | input | 3 | Window offset |
| acc_wdata | input | 8 | Write data (low byte) |
| acc_rdata | output | 8 | Read data from configuration space (0 while locked) |
| taskfile_stb | output | 1 | Access forwarded to the drive task file |
| cfg_unlocked | output | 1 | Configuration space is mapped into the window |
| drv0_rd_tim | output | 8 | Drive 0 read-cycle timing byte |
| drv0_wr_tim | output | 8 | Drive 0 write-cycle timing byte |
| drv1_rd_tim | output | 8 | Drive 1 read-cycle timing byte |
| drv1_wr_tim | output | 8 | Drive 1 write-cycle timing byte |
| cfg_setup | output | 2 | Address-setup field |
| cfg_rdy_dly | output | 2 | Ready-delay field |
| cfg_prefetch | output | 1 | Read-prefetch enable |

## Verification
Directed sequences first try the exact unlock order and then near-misses of it: a write between the reads, a byte-wide read in place of a wide one, a wrong key, and a single read before the key. These show whether the detector counts the access kind and width, or only the offsets. Bank routing is tried with bank B selected both before and after the locked 0xC0 write, and with the control byte at 0x85 and at other values. This separates which bank the host reaches from which bank each drive uses. A long random run then mixes locked and unlocked traffic, biased toward the key values, against a reference model in the bench, comparing read data, the strobe, the lock flag and every timing output after each access.

// File: rtl/hcw_pkg.sv
package hcw_pkg;
  typedef enum logic [1:0] {SQ_IDLE, SQ_ONE, SQ_TWO} seq_e;

  localparam logic [2:0] OFF_RD_TIM = 3'd0;
  localparam logic [2:0] OFF_WR_TIM = 3'd1;
  localparam logic [2:0] OFF_KEY    = 3'd2;
  localparam logic [2:0] OFF_CTRL   = 3'd3;
  localparam logic [2:0] OFF_VER    = 3'd5;
  localparam logic [2:0] OFF_MISC   = 3'd6;

  localparam int MISC_PF_BIT  = 6;
  localparam int MISC_SU_LSB  = 4;
  localparam int MISC_RDY_LSB = 1;
endpackage

// File: rtl/hcw_seq.sv
module hcw_seq
  import hcw_pkg::*;
#(
  parameter int          OW         = 3,
  parameter int          DW         = 8,
  parameter logic [2:0]  ARM_OFF    = 3'd1,
  parameter logic [7:0]  UNLOCK_KEY = 8'h03,
  parameter logic [7:0]  LOCK_KEY   = 8'h83
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          valid_i,
  input  logic          we_i,
  input  logic          wide_i,
  input  logic [OW-1:0] off_i,
  input  logic [DW-1:0] wdata_i,
  output logic          unlocked_o
);
  seq_e state_q, state_d;
  logic unl_q, unl_d;
  logic key_wr;

  assign key_wr = valid_i && we_i && !wide_i && (off_i == OW'(OFF_KEY));

  always_comb begin
    state_d = state_q;
    unl_d   = unl_q;
    if (valid_i) begin
      if (unl_q) begin
        state_d = SQ_IDLE;
        if (key_wr && wdata_i == DW'(LOCK_KEY)) unl_d = 1'b0;
      end else if (key_wr && wdata_i == DW'(UNLOCK_KEY) && state_q == SQ_TWO) begin
        unl_d   = 1'b1;
        state_d = SQ_IDLE;
      end else if (!we_i && wide_i && off_i == OW'(ARM_OFF)) begin
        state_d = (state_q == SQ_IDLE) ? SQ_ONE : SQ_TWO;
      end else begin
        state_d = SQ_IDLE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      unl_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      unl_q   <= unl_d;
    end
  end

  assign unlocked_o = unl_q;

  p_unlock_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!unl_q && state_q == SQ_TWO && key_wr && wdata_i == DW'(UNLOCK_KEY)) |=> unlocked_o);

  p_relock_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (unl_q && key_wr && wdata_i == DW'(LOCK_KEY)) |=> !unlocked_o);

  p_no_early_unlock_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!unl_q && state_q != SQ_TWO) |=> !unlocked_o);
endmodule

// File: rtl/hcw_regs.sv
module hcw_regs
  import hcw_pkg::*;
#(
  parameter int         OW           = 3,
  parameter int         DW           = 8,
  parameter int         NUM_BANKS    = 2,
  parameter logic [7:0] BANKB_EN_KEY = 8'hC0,
  parameter logic [7:0] DUAL_MAP     = 8'h85
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          unlocked_i,
  input  logic          valid_i,
  input  logic          we_i,
  input  logic [OW-1:0] off_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic [DW-1:0] drv0_rd_o,
  output logic [DW-1:0] drv0_wr_o,
  output logic [DW-1:0] drv1_rd_o,
  output logic [DW-1:0] drv1_wr_o,
  output logic [1:0]    setup_o,
  output logic [1:0]    rdy_o,
  output logic          prefetch_o
);
  localparam int BW = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;

  logic [NUM_BANKS-1:0][DW-1:0] rt_q, rt_d, wt_q, wt_d;
  logic [DW-1:0] ctrl_q, ctrl_d, misc_q, misc_d;
  logic [BW-1:0] sel_q, sel_d, act_bank, d1_bank;
  logic          ben_q, ben_d;
  logic          cfg_wr;

  assign cfg_wr   = valid_i && we_i && unlocked_i;
  assign act_bank = ben_q ? sel_q : '0;
  assign d1_bank  = (ctrl_q == DW'(DUAL_MAP)) ? BW'(1) : '0;

  always_comb begin
    rt_d   = rt_q;
    wt_d   = wt_q;
    ctrl_d = ctrl_q;
    misc_d = misc_q;
    sel_d  = sel_q;
    ben_d  = ben_q;
    if (valid_i && we_i && !unlocked_i && off_i == OW'(OFF_CTRL) && wdata_i == DW'(BANKB_EN_KEY))
      ben_d = 1'b1;
    if (cfg_wr) begin
      for (int b = 0; b < NUM_BANKS; b++) begin
        if (act_bank == BW'(b)) begin
          if (off_i == OW'(OFF_RD_TIM)) rt_d[b] = wdata_i;
          if (off_i == OW'(OFF_WR_TIM)) wt_d[b] = wdata_i;
        end
      end
      if (off_i == OW'(OFF_CTRL)) ctrl_d = wdata_i;
      if (off_i == OW'(OFF_MISC)) begin
        if (wdata_i < DW'(NUM_BANKS)) sel_d  = BW'(wdata_i);
        else                          misc_d = wdata_i;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rt_q   <= '0;
      wt_q   <= '0;
      ctrl_q <= '0;
      misc_q <= '0;
      sel_q  <= '0;
      ben_q  <= 1'b0;
    end else begin
      rt_q   <= rt_d;
      wt_q   <= wt_d;
      ctrl_q <= ctrl_d;
      misc_q <= misc_d;
      sel_q  <= sel_d;
      ben_q  <= ben_d;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (unlocked_i) begin
      case (off_i)
        OW'(OFF_RD_TIM): rdata_o = rt_q[act_bank];
        OW'(OFF_WR_TIM): rdata_o = wt_q[act_bank];
        OW'(OFF_CTRL):   rdata_o = ctrl_q;
        OW'(OFF_MISC):   rdata_o = misc_q;
        default:         rdata_o = '0;
      endcase
    end
  end

  assign drv0_rd_o  = rt_q[0];
  assign drv0_wr_o  = wt_q[0];
  assign drv1_rd_o  = rt_q[d1_bank];
  assign drv1_wr_o  = wt_q[d1_bank];
  assign prefetch_o = misc_q[MISC_PF_BIT];
  assign setup_o    = misc_q[MISC_SU_LSB +: 2];
  assign rdy_o      = misc_q[MISC_RDY_LSB +: 2];

  p_locked_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !unlocked_i |=> ($stable(rt_q) && $stable(wt_q) && $stable(ctrl_q) && $stable(misc_q) && $stable(sel_q)));

  p_bank_sel_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && off_i == OW'(OFF_MISC) && wdata_i == DW'(1)) |=> (sel_q == BW'(1) && $stable(misc_q)));

  p_bankb_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ben_q |=> ben_q);
endmodule

// File: rtl/hcw_window.sv
module hcw_window
  import hcw_pkg::*;
#(
  parameter int         OW           = 3,
  parameter int         DW           = 8,
  parameter int         NUM_BANKS    = 2,
  parameter logic [2:0] ARM_OFF      = 3'd1,
  parameter logic [7:0] UNLOCK_KEY   = 8'h03,
  parameter logic [7:0] LOCK_KEY     = 8'h83,
  parameter logic [7:0] BANKB_EN_KEY = 8'hC0,
  parameter logic [7:0] DUAL_MAP     = 8'h85
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc_valid,
  input  logic          acc_we,
  input  logic          acc_wide,
  input  logic [OW-1:0] acc_off,
  input  logic [DW-1:0] acc_wdata,
  output logic [DW-1:0] acc_rdata,
  output logic          taskfile_stb,
  output logic          cfg_unlocked,
  output logic [DW-1:0] drv0_rd_tim,
  output logic [DW-1:0] drv0_wr_tim,
  output logic [DW-1:0] drv1_rd_tim,
  output logic [DW-1:0] drv1_wr_tim,
  output logic [1:0]    cfg_setup,
  output logic [1:0]    cfg_rdy_dly,
  output logic          cfg_prefetch
);
  logic unl;

  hcw_seq #(.OW(OW), .DW(DW), .ARM_OFF(ARM_OFF), .UNLOCK_KEY(UNLOCK_KEY), .LOCK_KEY(LOCK_KEY)) u_seq (
    .clk(clk), .rst_n(rst_n), .valid_i(acc_valid), .we_i(acc_we), .wide_i(acc_wide),
    .off_i(acc_off), .wdata_i(acc_wdata), .unlocked_o(unl)
  );

  hcw_regs #(.OW(OW), .DW(DW), .NUM_BANKS(NUM_BANKS), .BANKB_EN_KEY(BANKB_EN_KEY), .DUAL_MAP(DUAL_MAP)) u_regs (
    .clk(clk), .rst_n(rst_n), .unlocked_i(unl), .valid_i(acc_valid), .we_i(acc_we),
    .off_i(acc_off), .wdata_i(acc_wdata), .rdata_o(acc_rdata),
    .drv0_rd_o(drv0_rd_tim), .drv0_wr_o(drv0_wr_tim), .drv1_rd_o(drv1_rd_tim), .drv1_wr_o(drv1_wr_tim),
    .setup_o(cfg_setup), .rdy_o(cfg_rdy_dly), .prefetch_o(cfg_prefetch)
  );

  assign cfg_unlocked = unl;
  assign taskfile_stb = acc_valid && !unl;

  p_version_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_unlocked && acc_valid && !acc_we && acc_off == OW'(OFF_VER)) |-> acc_rdata == '0);

  p_locked_rdata_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_unlocked |-> acc_rdata == '0);
endmodule

// File: tb/hcw_window_tb.sv
module hcw_window_tb;
  logic       clk, rst_n;
  logic       acc_valid, acc_we, acc_wide;
  logic [2:0] acc_off;
  logic [7:0] acc_wdata, acc_rdata;
  logic       taskfile_stb, cfg_unlocked, cfg_prefetch;
  logic [7:0] drv0_rd_tim, drv0_wr_tim, drv1_rd_tim, drv1_wr_tim;
  logic [1:0] cfg_setup, cfg_rdy_dly;

  int checks = 0, failures = 0;

  hcw_window u_dut (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_we(acc_we), .acc_wide(acc_wide),
    .acc_off(acc_off), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata), .taskfile_stb(taskfile_stb),
    .cfg_unlocked(cfg_unlocked), .drv0_rd_tim(drv0_rd_tim), .drv0_wr_tim(drv0_wr_tim),
    .drv1_rd_tim(drv1_rd_tim), .drv1_wr_tim(drv1_wr_tim), .cfg_setup(cfg_setup),
    .cfg_rdy_dly(cfg_rdy_dly), .cfg_prefetch(cfg_prefetch)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // reference model
  bit       m_unl, m_ben;
  int       m_seq;
  bit       m_sel;
  bit [7:0] m_rt[2], m_wt[2], m_ctrl, m_misc;

  function automatic int act_bank();
    return (m_ben && m_sel) ? 1 : 0;
  endfunction

  function automatic bit [7:0] exp_rdata(bit [2:0] off);
    if (!m_unl) return 8'h00;
    case (off)
      3'd0: return m_rt[act_bank()];
      3'd1: return m_wt[act_bank()];
      3'd3: return m_ctrl;
      3'd6: return m_misc;
      default: return 8'h00;
    endcase
  endfunction

  function automatic int d1_bank();
    return (m_ctrl == 8'h85) ? 1 : 0;
  endfunction

  task automatic model_update(bit we, bit wide, bit [2:0] off, bit [7:0] d);
    if (!m_unl) begin
      if (we && off == 3'd3 && d == 8'hC0) m_ben = 1;
      if (we && !wide && off == 3'd2 && d == 8'h03 && m_seq == 2) begin
        m_unl = 1; m_seq = 0;
      end else if (!we && wide && off == 3'd1) m_seq = (m_seq == 0) ? 1 : 2;
      else m_seq = 0;
    end else begin
      m_seq = 0;
      if (we) begin
        case (off)
          3'd0: m_rt[act_bank()] = d;
          3'd1: m_wt[act_bank()] = d;
          3'd2: if (!wide && d == 8'h83) m_unl = 0;
          3'd3: m_ctrl = d;
          3'd6: if (d < 2) m_sel = d[0]; else m_misc = d;
          default: ;
        endcase
      end
    end
  endtask

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic chk_state(string req);
    chk(cfg_unlocked == m_unl, req, "unlocked", cfg_unlocked, m_unl);
    chk(drv0_rd_tim == m_rt[0], req, "drv0_rd", drv0_rd_tim, m_rt[0]);
    chk(drv0_wr_tim == m_wt[0], req, "drv0_wr", drv0_wr_tim, m_wt[0]);
    chk(drv1_rd_tim == m_rt[d1_bank()], req, "drv1_rd", drv1_rd_tim, m_rt[d1_bank()]);
    chk(drv1_wr_tim == m_wt[d1_bank()], req, "drv1_wr", drv1_wr_tim, m_wt[d1_bank()]);
    chk(cfg_prefetch == m_misc[6], req, "prefetch", cfg_prefetch, m_misc[6]);
    chk(cfg_setup == m_misc[5:4], req, "setup", cfg_setup, m_misc[5:4]);
    chk(cfg_rdy_dly == m_misc[2:1], req, "rdy_dly", cfg_rdy_dly, m_misc[2:1]);
  endtask

  task automatic access(bit we, bit wide, bit [2:0] off, bit [7:0] d, string req);
    bit [7:0] er;
    @(negedge clk);
    acc_valid = 1'b1; acc_we = we; acc_wide = wide; acc_off = off; acc_wdata = d;
    #2;
    er = exp_rdata(off);
    if (!we) chk(acc_rdata == er, req, "rdata", acc_rdata, er);
    chk(taskfile_stb == !m_unl, req, "taskfile_stb", taskfile_stb, !m_unl);
    @(posedge clk);
    #1;
    acc_valid = 1'b0;
    model_update(we, wide, off, d);
    chk_state(req);
  endtask

  task automatic unlock_seq(string req);
    access(0, 1, 3'd1, 8'h00, req);
    access(0, 1, 3'd1, 8'h00, req);
    access(1, 0, 3'd2, 8'h03, req);
  endtask

  initial begin
    #(200000 * 20);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    acc_valid = 0; acc_we = 0; acc_wide = 0; acc_off = 0; acc_wdata = 0;
    m_unl = 0; m_ben = 0; m_seq = 0; m_sel = 0; m_ctrl = 0; m_misc = 0;
    m_rt[0] = 0; m_rt[1] = 0; m_wt[0] = 0; m_wt[1] = 0;
    rst_n = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk_state("R1");

    // broken sequences: R3
    access(0, 1, 3'd1, 0, "R3"); access(1, 0, 3'd4, 8'h11, "R3");
    access(0, 1, 3'd1, 0, "R3"); access(1, 0, 3'd2, 8'h03, "R3");
    chk(cfg_unlocked == 0, "R3", "write between reads", cfg_unlocked, 0);
    access(0, 1, 3'd1, 0, "R3"); access(0, 0, 3'd1, 0, "R3"); access(1, 0, 3'd2, 8'h03, "R3");
    access(0, 1, 3'd1, 0, "R3"); access(0, 1, 3'd1, 0, "R3"); access(1, 0, 3'd2, 8'h04, "R3");
    access(1, 0, 3'd2, 8'h03, "R3");
    chk(cfg_unlocked == 0, "R3", "wrong key", cfg_unlocked, 0);
    access(0, 1, 3'd1, 0, "R3"); access(0, 1, 3'd1, 0, "R3"); access(0, 1, 3'd1, 0, "R3");
    access(1, 0, 3'd2, 8'h03, "R3");
    chk(cfg_unlocked == 1, "R3", "three reads still armed", cfg_unlocked, 1);
    access(1, 0, 3'd2, 8'h83, "R5");

    // locked writes change nothing: R4
    access(1, 0, 3'd0, 8'h5A, "R4"); access(1, 0, 3'd6, 8'h7E, "R4"); access(1, 1, 3'd1, 8'hA5, "R4");

    // unlock and program bank A: R2 R6
    unlock_seq("R2");
    access(1, 0, 3'd0, 8'h21, "R6"); access(1, 0, 3'd1, 8'h32, "R6");
    access(0, 0, 3'd0, 0, "R6"); access(0, 0, 3'd1, 0, "R6");
    // select B without enable: R10
    access(1, 0, 3'd6, 8'h01, "R10"); access(1, 0, 3'd0, 8'h43, "R10");
    access(0, 0, 3'd0, 0, "R10");
    chk(drv0_rd_tim == 8'h43, "R10", "bank B disabled routes to A", drv0_rd_tim, 8'h43);
    // version and unused: R9
    access(1, 0, 3'd5, 8'hFF, "R9"); access(0, 0, 3'd5, 0, "R9");
    access(1, 0, 3'd4, 8'h99, "R9"); access(0, 0, 3'd4, 0, "R9"); access(0, 0, 3'd7, 0, "R9");
    access(1, 0, 3'd2, 8'h55, "R5"); access(0, 0, 3'd2, 0, "R5");
    access(1, 0, 3'd2, 8'h83, "R5");
    access(1, 0, 3'd3, 8'hC0, "R10");
    unlock_seq("R2");
    access(1, 0, 3'd6, 8'h01, "R7"); access(1, 0, 3'd0, 8'h6C, "R7"); access(1, 0, 3'd1, 8'h7D, "R7");
    access(1, 0, 3'd3, 8'h85, "R8"); access(0, 0, 3'd3, 0, "R8");
    chk(drv1_rd_tim == 8'h6C, "R8", "drive1 on bank B", drv1_rd_tim, 8'h6C);
    access(1, 0, 3'd6, 8'h00, "R7"); access(0, 0, 3'd0, 0, "R7");
    access(1, 0, 3'd6, 8'h56, "R7"); access(0, 0, 3'd6, 0, "R7");
    access(1, 0, 3'd3, 8'h84, "R8");

    // random traffic
    for (int i = 0; i < 4000; i++) begin
      int k; bit [7:0] d;
      k = $urandom % 16;
      if (k == 0 && !m_unl) unlock_seq("R2");
      else if (k == 1 && m_unl) access(1, 0, 3'd2, 8'h83, "R5");
      else begin
        case ($urandom % 8)
          0: d = 8'h00; 1: d = 8'h01; 2: d = 8'h03; 3: d = 8'h85; 4: d = 8'hC0;
          default: d = 8'($urandom);
        endcase
        access(1'($urandom), 1'($urandom), 3'($urandom), d, "R6");
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule